// File: doc/BRIEF.md
# Write-Only Two-Wire Control Target

This block is the receiving end of a two-wire (I2C) control link. It is meant for a chip whose settings are only ever written by a host. It runs entirely on the system clock. Both bus lines are brought into that clock through flop synchronizers. Bus events are found by comparing each synchronized line with its value one cycle earlier, so the bus must be slow relative to the system clock.

A transfer opens with a START. The first byte carries a seven-bit target address and a direction bit. The upper five address bits are fixed, and the next two come from two strap pins, so up to four of these targets can share one bus. Once the address matches and the direction is write, each following byte is handed to a downstream command decoder as its own word, together with a single-cycle strobe. The target acknowledges the address and every data byte for as long as the host keeps sending.

Any other address, and any read request, leaves the target silent until the bus shows a new START or a STOP. The pad is open-drain and lives outside this block. Here it is represented by one enable output: when it is high, the pad pulls SDA low.

Top module: `i2c_wr_target`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state begins reception of an address byte, starting from its most significant bit.
- R2: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. A START after it receives a fresh address byte, beginning at its most significant bit, even when the STOP arrived in the middle of a byte.
- R3: The address byte is acknowledged exactly when it equals {1,0,0,0,1,addr_sel[1],addr_sel[0],0}. This is 0x88, 0x8A, 0x8C or 0x8E for addr_sel = 0, 1, 2 or 3.
- R4: After an address that does not match, including a matching address with the direction bit set to 1, the target neither drives SDA nor raises rx_valid until the next START or STOP.
- R5: An acknowledge asserts sda_oe only while SCL is low, after the falling edge that ends the eighth bit. sda_oe stays steady while SCL is high and is released after the SCL falling edge that ends the ninth pulse.
- R6: Each data byte that follows a matching address appears on rx_data, with the first bit received in bit 7, during a single-cycle rx_valid pulse raised after the eighth bit's falling SCL edge.
- R7: Every data byte in a transfer is acknowledged, with no limit on the number of bytes.
- R8: A repeated START in the middle of a transfer discards the current transfer. The next byte is treated as an address.
- R9: During and right after reset, sda_oe and rx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap pins giving the two variable address bits |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| rx_data | output | 8 | Last received data byte, MSB being the first bit on the wire |
| rx_valid | output | 1 | One-cycle strobe marking a new byte on rx_data |

## Verification
Several properties are checked on every cycle. A START always lands in address reception with the bit count cleared, and a STOP always lands in idle with SDA released. The acknowledge drive never changes while SCL is high, and only rises with SCL low. rx_valid is one cycle wide and comes only from a completed data byte, and the ignoring state stays silent. Other points need whole bus transactions and only the bench's scenarios can show them: which of the candidate address bytes each strap setting accepts, that all 256 data values survive the shift path in order, that a STOP in the middle of a byte restarts the count, and that a repeated START re-arms address matching.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Protocol constants
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam int PIN_W  = 2;
    localparam logic [BYTE_W-PIN_W-2:0] ADDR_FIXED = 5'b10001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } tgt_state_e;

    // Events seen on the synchronized bus in one system clock
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    // A byte addresses this target for writing when the fixed part,
    // the strap bits and a zero direction bit all line up.
    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [PIN_W-1:0]  pins);
        return (b[BYTE_W-1:PIN_W+1] == ADDR_FIXED) &&
               (b[PIN_W:1] == pins) &&
               (b[0] == 1'b0);
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= RST_VAL;
                else     pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2cw_events.sv
module i2cw_events
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t ev
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SCL must be high in both samples for a line condition
    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          ev,
    input  logic [PIN_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    tgt_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;

    assign byte_done = ev.fall && (bit_cnt == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_DATA: begin
                        if (ev.rise && bit_cnt != CNT_FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, addr_sel)) begin
                                    state  <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                                state    <= ST_DATA_ACK;
                                sda_oe   <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        sda_oe <= 1'b0;
                    end
                    default: begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (rst)
        ev.start && !ev.stop |=> (state == ST_ADDR) && (bit_cnt == '0));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE) && !sda_oe);

    assert_skip_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_oe && !rx_valid));

    assert_oe_rise_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    assert_oe_steady_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && !ev.rise && !ev.start && !ev.stop) |=> $stable(sda_oe) || !ev.scl);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_strobe_source_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (state == ST_DATA_ACK) && sda_oe);

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    bus_evt_t           ev;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_sync
            i2cw_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw_lines[i]),
                .q   (sync_lines[i])
            );
        end
    endgenerate

    i2cw_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_s (sync_lines[1]),
        .sda_s (sync_lines[0]),
        .ev    (ev)
    );

    i2cw_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !rx_valid));

endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    wire        sda_line = sda_h & ~sda_oe;

    always #2 clk = ~clk;

    i2c_wr_target u_i2c_wr_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int dbl    = 0;
    logic       vprev = 1'b0;
    logic [7:0] rxbuf [0:511];

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rxbuf[vcount % 512] = rx_data;
                vcount = vcount + 1;
                if (vprev) dbl = dbl + 1;
            end
            vprev = rx_valid;
        end
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_c(Q);
        scl_h = 1'b1; wait_c(Q);
        sda_h = 1'b0; wait_c(Q);
        scl_h = 1'b0; wait_c(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_c(Q);
        scl_h = 1'b1; wait_c(Q);
        sda_h = 1'b1; wait_c(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i]; wait_c(Q);
            scl_h = 1'b1; wait_c(2*Q);
            scl_h = 1'b0; wait_c(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack,
                             output bit oe_early, output bit oe_after);
        send_bits(b, 8);
        sda_h = 1'b1;
        oe_early = sda_oe;
        wait_c(Q);
        scl_h = 1'b1; wait_c(Q);
        ack = !sda_line;
        wait_c(Q);
        scl_h = 1'b0; wait_c(Q);
        oe_after = sda_oe;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit ack, oe_e, oe_a;
        int base;
        wait_c(5);
        check(sda_oe == 1'b0 && rx_valid == 1'b0, "R9 reset outputs", {sda_oe, rx_valid}, 0);
        rst = 1'b0;
        wait_c(4);
        check(sda_oe == 1'b0 && rx_valid == 1'b0, "R9 after reset", {sda_oe, rx_valid}, 0);

        // Address sweep: every strap setting against 0x80..0x8F
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            for (int c = 8'h80; c <= 8'h8F; c++) begin
                bit exp_hit;
                exp_hit = (c == (8'h88 | (s << 1)));
                base = vcount;
                bus_start();
                send_byte(8'(c), ack, oe_e, oe_a);
                check(ack == exp_hit, exp_hit ? "R3 address ack" : "R4 address nack",
                      ack, exp_hit);
                if (exp_hit) begin
                    check(oe_e == 1'b1 && oe_a == 1'b0, "R5 ack window", {oe_e, oe_a}, 2);
                    send_byte(8'(s * 16 + c), ack, oe_e, oe_a);
                    check(ack && vcount == base + 1 && rxbuf[base % 512] == 8'(s * 16 + c),
                          "R6 data after match", rxbuf[base % 512], 8'(s * 16 + c));
                end else begin
                    send_byte(8'hA5, ack, oe_e, oe_a);
                    check(!ack && vcount == base, "R4 data ignored", vcount - base, 0);
                end
                bus_stop();
                check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
            end
        end

        // Full data sweep in one long transfer
        addr_sel = 2'd2;
        base = vcount;
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        check(ack, "R3 address 0x8C", ack, 1);
        begin
            int nacks = 0;
            for (int d = 0; d < 256; d++) begin
                send_byte(8'(d), ack, oe_e, oe_a);
                if (!ack) nacks++;
            end
            check(nacks == 0, "R7 every byte acked", nacks, 0);
        end
        bus_stop();
        check(vcount == base + 256, "R6 strobe count", vcount - base, 256);
        begin
            int bad = 0;
            for (int d = 0; d < 256; d++)
                if (rxbuf[(base + d) % 512] != 8'(d)) bad++;
            check(bad == 0, "R6 byte values in order", bad, 0);
        end
        check(dbl == 0, "R6 single-cycle strobe", dbl, 0);

        // Repeated START in the middle of a transfer
        base = vcount;
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        send_byte(8'h3C, ack, oe_e, oe_a);
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        check(ack, "R8 address after repeated start", ack, 1);
        send_byte(8'hC3, ack, oe_e, oe_a);
        bus_stop();
        check(vcount == base + 2 && rxbuf[(base + 1) % 512] == 8'hC3,
              "R8 data after repeated start", rxbuf[(base + 1) % 512], 8'hC3);

        // Repeated START after a rejected address
        base = vcount;
        bus_start();
        send_byte(8'h90, ack, oe_e, oe_a);
        check(!ack, "R4 foreign address", ack, 0);
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        check(ack, "R1 start leaves ignore state", ack, 1);
        send_byte(8'h77, ack, oe_e, oe_a);
        bus_stop();
        check(vcount == base + 1 && rxbuf[base % 512] == 8'h77,
              "R1 data after re-arm", rxbuf[base % 512], 8'h77);

        // STOP in the middle of a byte, then a clean transfer
        base = vcount;
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        send_bits(8'hFF, 3);
        bus_stop();
        check(vcount == base && sda_oe == 1'b0, "R2 partial byte dropped", vcount - base, 0);
        bus_start();
        send_byte(8'h8C, ack, oe_e, oe_a);
        send_byte(8'h5A, ack, oe_e, oe_a);
        bus_stop();
        check(ack && vcount == base + 1 && rxbuf[base % 512] == 8'h5A,
              "R2 count restarts at bit 7", rxbuf[base % 512], 8'h5A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule